// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns a 36-bit proto segment identifier into a scattered 36-bit virtual segment identifier (VSID). It multiplies the proto value by the fixed 28-bit prime 200730139. It then reduces the product modulo 2^36 − 1. The reduction adds the high part of the product onto the low part and applies one conditional increment, so the block needs no divider and no second multiplier. The multiplier is co-prime to the modulus, so every legal proto value maps to its own VSID.

The proto value is built from the request. In kernel mode it is the 256 MB segment number of a 64-bit effective address. In user mode it joins a 19-bit context number to the low 16 segment-number bits of the address. A request enters through a valid/ready handshake. The result appears on a valid-qualified output exactly three cycles later. The block takes one new request in every cycle.

Top module: `vsid_scrambler`

## Requirements
- R1: For every proto value that is not reserved, out_vsid equals (proto × 200730139) mod (2^36 − 1).
- R2: When in_mode is 1 (kernel), the proto value is in_ea[63:28].
- R3: When in_mode is 0 (user), the proto value is {1'b0, in_ctx[18:0], in_ea[43:28]}. In this mode in_ea[63:44] and in_ea[27:0] have no effect on the result.
- R4: A request accepted on a rising edge (in_valid and in_ready both high) raises out_valid after exactly the third rising edge that follows. Back-to-back requests give back-to-back results, in the order they arrived.
- R5: A proto value that is all ones, or whose top two bits are 2'b10, is reserved. It yields out_err = 1 and out_vsid = 0 in its result cycle.
- R6: A result with out_err = 0 is never 36'hFFFFFFFFF.
- R7: While out_valid is low, out_vsid is 0 and out_err is 0.
- R8: While rst_n is low, out_valid, out_err and out_vsid are 0. in_ready is high whenever rst_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_mode | input | 1 | 1 = kernel proto value, 0 = user proto value |
| in_ctx | input | 19 | Context number (user mode only) |
| in_ea | input | 64 | Effective address |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Request carried a reserved proto value |
| out_vsid | output | 36 | Scrambled segment identifier |

## Verification
The checker compares, on every cycle, the output valid against its own three-deep copy of the accepted-request history. It compares the error flag against a reserved-value test that it computes straight from the inputs. It also checks that error results and idle cycles carry zero and that a good result is never all ones. Only the bench scenarios can show that the VSID value is arithmetically right. They check each result against a remainder taken with a full 64-bit product. They also show that the user-mode address bits outside the 16-bit field change nothing, and that results keep their order through streams and gaps.

// File: rtl/vsid_pkg.sv
// Shared constants and the mode encoding for the segment identifier scrambler.
package vsid_pkg;
    localparam int VSID_W_D    = 36;          // identifier width; modulus is 2^VSID_W-1
    localparam int EA_W_D      = 64;          // effective address width
    localparam int SEG_SHIFT_D = 28;          // 256 MB segments
    localparam int CTX_W_D     = 19;          // user context width
    localparam int UESID_W_D   = 16;          // user segment-number bits kept
    localparam int MULT_W_D    = 28;          // multiplier width
    localparam logic [MULT_W_D-1:0] VSID_MULT_D = 28'd200730139;

    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } vsid_mode_e;
endpackage

// File: rtl/vsid_proto_form.sv
// Builds the proto value from the mode, context and address, and flags reserved
// proto values. Purely combinational.
// Assumes EA_W - SEG_SHIFT == VSID_W and CTX_W + UESID_W < VSID_W.
module vsid_proto_form #(
    parameter int VSID_W    = vsid_pkg::VSID_W_D,
    parameter int EA_W      = vsid_pkg::EA_W_D,
    parameter int SEG_SHIFT = vsid_pkg::SEG_SHIFT_D,
    parameter int CTX_W     = vsid_pkg::CTX_W_D,
    parameter int UESID_W   = vsid_pkg::UESID_W_D
) (
    input  logic              mode,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [EA_W-1:0]   ea,
    output logic [VSID_W-1:0] proto,
    output logic              reserved
);
    localparam int PAD_W = VSID_W - CTX_W - UESID_W;

    logic [VSID_W-1:0] kern_proto;
    logic [VSID_W-1:0] user_proto;

    assign kern_proto = ea[SEG_SHIFT +: VSID_W];
    assign user_proto = {{PAD_W{1'b0}}, ctx, ea[SEG_SHIFT +: UESID_W]};

    // Select the proto value for the requested mode.
    always_comb begin
        if (mode == vsid_pkg::MODE_KERNEL) proto = kern_proto;
        else                               proto = user_proto;
    end

    // Reserved: all ones, or top two bits equal to 2'b10.
    always_comb begin
        reserved = (&proto) || (proto[VSID_W-1 -: 2] == 2'b10);
    end
endmodule

// File: rtl/vsid_mul_stage.sv
// Stage 1: registers the full product proto * MULT together with valid and error.
// Assumes the product fits in VSID_W + MULT_W bits.
module vsid_mul_stage #(
    parameter int VSID_W = vsid_pkg::VSID_W_D,
    parameter int MULT_W = vsid_pkg::MULT_W_D,
    parameter logic [MULT_W-1:0] MULT = vsid_pkg::VSID_MULT_D
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       err_in,
    input  logic [VSID_W-1:0]          proto,
    output logic                       vld_q,
    output logic                       err_q,
    output logic [VSID_W+MULT_W-1:0]   prod_q
);
    localparam int PROD_W = VSID_W + MULT_W;

    // Capture the product of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
            prod_q <= '0;
        end else begin
            vld_q  <= take;
            err_q  <= take & err_in;
            prod_q <= take ? (PROD_W'(proto) * PROD_W'(MULT)) : '0;
        end
    end
endmodule

// File: rtl/vsid_fold_stage.sv
// Stage 2: folds the product onto the low VSID_W bits (high part + low part).
// The result stays below 2^VSID_W + 2^MULT_W, so it fits in VSID_W+1 bits.
module vsid_fold_stage #(
    parameter int VSID_W = vsid_pkg::VSID_W_D,
    parameter int MULT_W = vsid_pkg::MULT_W_D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vld_in,
    input  logic                      err_in,
    input  logic [VSID_W+MULT_W-1:0]  prod,
    output logic                      vld_q,
    output logic                      err_q,
    output logic [VSID_W:0]           sum_q
);
    localparam int PROD_W = VSID_W + MULT_W;
    localparam int HPAD_W = VSID_W + 1 - MULT_W;

    logic [VSID_W:0] lo_ext;
    logic [VSID_W:0] hi_ext;

    assign lo_ext = {1'b0, prod[VSID_W-1:0]};
    assign hi_ext = {{HPAD_W{1'b0}}, prod[PROD_W-1:VSID_W]};

    // Register the end-around fold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
            sum_q <= '0;
        end else begin
            vld_q <= vld_in;
            err_q <= err_in;
            sum_q <= lo_ext + hi_ext;
        end
    end
endmodule

// File: rtl/vsid_fix_stage.sv
// Stage 3: adds one when sum+1 carries past bit VSID_W, keeps the low VSID_W bits,
// and forces zero on error or idle cycles.
module vsid_fix_stage #(
    parameter int VSID_W = vsid_pkg::VSID_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_in,
    input  logic              err_in,
    input  logic [VSID_W:0]   sum,
    output logic              vld_q,
    output logic              err_q,
    output logic [VSID_W-1:0] vsid_q
);
    logic [VSID_W:0] sum_inc;
    logic [VSID_W:0] fixed;

    // Correction: sum + ((sum + 1) >> VSID_W).
    always_comb begin
        sum_inc = sum + 1'b1;
        fixed   = sum + {{VSID_W{1'b0}}, sum_inc[VSID_W]};
    end

    // Register the final result, zero unless a good request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
            vsid_q <= '0;
        end else begin
            vld_q  <= vld_in;
            err_q  <= vld_in & err_in;
            vsid_q <= (vld_in && !err_in) ? fixed[VSID_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/vsid_scrambler.sv
// Top: three-stage scrambler (multiply, fold, correct) with a fixed latency of 3.
// It takes one request per cycle; the output has no back-pressure, so in_ready
// stays high.
module vsid_scrambler #(
    parameter int VSID_W    = vsid_pkg::VSID_W_D,
    parameter int EA_W      = vsid_pkg::EA_W_D,
    parameter int SEG_SHIFT = vsid_pkg::SEG_SHIFT_D,
    parameter int CTX_W     = vsid_pkg::CTX_W_D,
    parameter int UESID_W   = vsid_pkg::UESID_W_D,
    parameter int MULT_W    = vsid_pkg::MULT_W_D,
    parameter logic [MULT_W-1:0] MULT = vsid_pkg::VSID_MULT_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic [EA_W-1:0]   in_ea,
    output logic              out_valid,
    output logic              out_err,
    output logic [VSID_W-1:0] out_vsid
);
    localparam int PROD_W = VSID_W + MULT_W;

    logic [VSID_W-1:0] proto;
    logic              reserved;
    logic              take;
    logic              s1_vld, s1_err;
    logic [PROD_W-1:0] s1_prod;
    logic              s2_vld, s2_err;
    logic [VSID_W:0]   s2_sum;

    assign in_ready = 1'b1;
    assign take     = in_valid & in_ready;

    vsid_proto_form #(
        .VSID_W(VSID_W), .EA_W(EA_W), .SEG_SHIFT(SEG_SHIFT),
        .CTX_W(CTX_W), .UESID_W(UESID_W)
    ) u_form (
        .mode(in_mode), .ctx(in_ctx), .ea(in_ea),
        .proto(proto), .reserved(reserved)
    );

    vsid_mul_stage #(.VSID_W(VSID_W), .MULT_W(MULT_W), .MULT(MULT)) u_mul (
        .clk(clk), .rst_n(rst_n), .take(take), .err_in(reserved), .proto(proto),
        .vld_q(s1_vld), .err_q(s1_err), .prod_q(s1_prod)
    );

    vsid_fold_stage #(.VSID_W(VSID_W), .MULT_W(MULT_W)) u_fold (
        .clk(clk), .rst_n(rst_n), .vld_in(s1_vld), .err_in(s1_err), .prod(s1_prod),
        .vld_q(s2_vld), .err_q(s2_err), .sum_q(s2_sum)
    );

    vsid_fix_stage #(.VSID_W(VSID_W)) u_fix (
        .clk(clk), .rst_n(rst_n), .vld_in(s2_vld), .err_in(s2_err), .sum(s2_sum),
        .vld_q(out_valid), .err_q(out_err), .vsid_q(out_vsid)
    );
endmodule

// File: rtl/vsid_scrambler_chk.sv
// Checker for vsid_scrambler. It keeps its own three-deep history of accepted
// requests and of the reserved test, computed from the inputs alone.
module vsid_scrambler_chk #(
    parameter int VSID_W    = vsid_pkg::VSID_W_D,
    parameter int EA_W      = vsid_pkg::EA_W_D,
    parameter int SEG_SHIFT = vsid_pkg::SEG_SHIFT_D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_mode,
    input logic [EA_W-1:0]   in_ea,
    input logic              out_valid,
    input logic              out_err,
    input logic [VSID_W-1:0] out_vsid
);
    logic [VSID_W-1:0] kseg;
    logic              bad_now;
    logic [2:0]        vld_h;
    logic [2:0]        err_h;

    // User proto values have a zero top bit, so only kernel ones can be reserved.
    assign kseg    = in_ea[SEG_SHIFT +: VSID_W];
    assign bad_now = in_mode && ((&kseg) || (kseg[VSID_W-1:VSID_W-2] == 2'b10));

    // Shift the accepted-request history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_h <= '0;
            err_h <= '0;
        end else begin
            vld_h <= {vld_h[1:0], in_valid & in_ready};
            err_h <= {err_h[1:0], in_valid & in_ready & bad_now};
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_h[2]); // R4
    AST_ERR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_err == err_h[2])); // R5
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_vsid == '0)); // R5
    AST_NO_RESERVED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_vsid != '1)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_vsid == '0 && !out_err)); // R7
endmodule

bind vsid_scrambler vsid_scrambler_chk #(
    .VSID_W(VSID_W), .EA_W(EA_W), .SEG_SHIFT(SEG_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_ea(in_ea), .out_valid(out_valid),
    .out_err(out_err), .out_vsid(out_vsid)
);

// File: tb/vsid_scrambler_bench.sv
`timescale 1ns/1ps
module vsid_scrambler_bench;
    localparam logic [35:0] ALL1 = 36'hF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [18:0] in_ctx = '0;
    logic [63:0] in_ea = '0;
    logic        in_ready, out_valid, out_err;
    logic [35:0] out_vsid;

    vsid_scrambler u_vsid_scrambler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_ctx(in_ctx), .in_ea(in_ea),
        .out_valid(out_valid), .out_err(out_err), .out_vsid(out_vsid)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    longint cyc = 0;
    bit    live = 1'b0;
    bit    done = 1'b0;

    typedef struct {
        logic [35:0] vsid;
        logic        err;
        longint      due;
        string       req;
    } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [35:0] ref_vsid(logic [35:0] p);
        logic [63:0] prod;
        prod = {28'd0, p} * 64'd200730139;
        return 36'(prod % 64'h0000_000F_FFFF_FFFF);
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Drive one request for one cycle; the expected result comes from the requirements.
    task automatic send(bit mode, logic [18:0] ctx, logic [63:0] ea, string req);
        exp_t e;
        logic [35:0] p;
        bit bad;
        p = mode ? ea[63:28] : {1'b0, ctx, ea[43:28]};
        bad = (p == ALL1) || (p[35:34] == 2'b10);
        e.err  = bad;
        e.vsid = bad ? 36'd0 : ref_vsid(p);
        e.due  = cyc + 3;
        e.req  = req;
        in_valid = 1'b1; in_mode = mode; in_ctx = ctx; in_ea = ea;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard: compare each result in its due cycle; idle cycles must be quiet.
    always @(negedge clk) begin
        if (live && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4", "unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_vsid == e.vsid, e.req, "vsid (R1)", 64'(out_vsid), 64'(e.vsid));
                    check(out_err == e.err, e.req, "err (R5)", 64'(out_err), 64'(e.err));
                    check(cyc == e.due, "R4", "latency", 64'(cyc), 64'(e.due));
                    if (!out_err)
                        check(out_vsid != ALL1, "R6", "reserved output", 64'(out_vsid), 64'(0));
                end
            end else begin
                check(out_vsid == 36'd0 && !out_err, "R7", "idle output",
                      {27'd0, out_err, out_vsid}, 64'd0);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
        finish_run();
    end

    initial begin
        logic [63:0] r;
        // R8: reset state
        repeat (3) @(negedge clk);
        check(!out_valid && !out_err && out_vsid == 36'd0, "R8", "reset outputs",
              {26'd0, out_valid, out_err, out_vsid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "ready after reset", 64'(in_ready), 64'd1);
        live = 1'b1;

        // R1/R2: kernel edges and low/high sweeps, back to back
        send(1'b1, '0, {36'd0, 28'h123_4567}, "R2");
        send(1'b1, '0, {36'd1, 28'h0}, "R1");
        send(1'b1, '0, {ALL1 - 36'd1, 28'hFFF_FFFF}, "R1");
        send(1'b1, '0, {36'hC_0000_0000, 28'h0}, "R2");
        for (int i = 0; i < 256; i++) send(1'b1, '0, {36'(i), 28'(i * 7)}, "R2");
        idle(2);
        for (int i = 2; i < 258; i++) send(1'b1, '0, {ALL1 - 36'(i), 28'd0}, "R1");
        idle(5);

        // R5: reserved proto values in kernel mode
        send(1'b1, '0, {ALL1, 28'd0}, "R5");
        for (int i = 0; i < 64; i++) send(1'b1, '0, {36'h8_0000_0000 + 36'(i), 28'd5}, "R5");
        send(1'b1, '0, {36'hB_FFFF_FFFF, 28'd0}, "R5");
        send(1'b1, '0, {36'hC_0000_0000, 28'd0}, "R5");
        idle(4);

        // R3: user mode; address bits outside [43:28] must not matter
        send(1'b0, 19'h7FFFF, {20'hFFFFF, 16'hFFFF, 28'hFFF_FFFF}, "R3");
        send(1'b0, 19'h7FFFF, {20'h00000, 16'hFFFF, 28'h000_0000}, "R3");
        send(1'b0, 19'h0, {20'hABCDE, 16'h0, 28'h1234567}, "R3");
        for (int c = 0; c < 128; c++)
            send(1'b0, 19'(c * 4099), {$urandom, $urandom}, "R3");
        idle(4);

        // R1/R4: random mix with random gaps
        for (int i = 0; i < 3000; i++) begin
            r = {$urandom, $urandom};
            send(1'($urandom), 19'($urandom), r, "R1");
            if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
        end
        idle(8);
        check(q.size() == 0, "R4", "results outstanding", 64'(q.size()), 64'd0);
        done = 1'b1;
        finish_run();
    end
endmodule